// File: doc/BRIEF.md
# Dual-Mode 40-bit Accumulator ALU

This block is the arithmetic and logic stage of a fixed-point signal-processing datapath. It takes a 40-bit operand bus and one of two 40-bit accumulators as its second input. It applies an add, subtract, bitwise Boolean or load operation, and writes the result into one of the two accumulators on a clock edge. Operands are sign-extended from a selectable 16-, 32- or 40-bit size. The upper 8 bits of each accumulator are guard bits, so a result that overflows a 16- or 32-bit range is kept in full while a flag reports the overflow.

A split mode turns the unit into two independent 16-bit ALUs. These work on bits 15..0 and bits 31..16 of both inputs in the same cycle. No carry passes between the two halves, and each half reports its own overflow. The guard, high and low fields of the destination accumulator can each be enabled or disabled for writing. This lets a caller update only part of an accumulator. Both accumulators are visible on the outputs at all times, so each field can be read on its own.

Top module: `dsp_alu40`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), both accumulators and all four flags (ovf_lo_o, ovf_hi_o, zero_o, neg_o) are zero.
- R2: With split_i=0 and size_i=2 or 3 (40-bit), op_i=0 writes acc+opnd and op_i=1 writes acc-opnd, modulo 2^40. ovf_lo_o is set when the true signed result does not fit in 40 bits.
- R3: With size_i=0 (16-bit) or size_i=1 (32-bit), the operand and the accumulator input are sign-extended from bit 15 or bit 31 to 40 bits before the operation. All 40 bits of the result are written. ovf_lo_o is set when the result does not fit in 16 or 32 signed bits respectively.
- R4: op_i=2, 3 and 4 write the bitwise AND, OR and XOR of the two sign-extended inputs. op_i=5, 6 and 7 write the sign-extended operand (load). None of these sets an overflow flag.
- R5: With split_i=1, size_i is ignored. The low 16 bits of the result come from the operation on bits 15..0 of both inputs, and bits 31..16 come from the operation on bits 31..16, with no carry between them. Bits 39..32 copy bit 31. ovf_lo_o and ovf_hi_o flag signed 16-bit overflow of the low and high halves.
- R6: acc_sel_i selects the accumulator used as the second input: 0 selects A and 1 selects B.
- R7: When wr_en_i is 1, the result goes to the accumulator chosen by dst_sel_i (0=A, 1=B) at the rising clock edge, and the other accumulator is unchanged. When wr_en_i is 0, both accumulators and all flags hold.
- R8: fld_we_i gates the destination fields: bit 0 enables bits 15..0, bit 1 enables bits 31..16, and bit 2 enables bits 39..32. A field whose bit is 0 keeps its old value.
- R9: On every write, zero_o is set when the full 40-bit result is zero and neg_o copies result bit 39. Outside split mode, ovf_hi_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_i | input | 40 | Operand bus |
| acc_sel_i | input | 1 | Second-input accumulator: 0=A, 1=B |
| op_i | input | 3 | 0 add, 1 sub (acc-opnd), 2 AND, 3 OR, 4 XOR, 5-7 load |
| size_i | input | 2 | 0=16-bit, 1=32-bit, 2/3=40-bit |
| split_i | input | 1 | Dual 16-bit mode |
| dst_sel_i | input | 1 | Destination: 0=A, 1=B |
| wr_en_i | input | 1 | Write result and flags at the clock edge |
| fld_we_i | input | 3 | Field write enables {guard, high, low} |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| ovf_lo_o | output | 1 | Overflow (whole result, or low half in split mode) |
| ovf_hi_o | output | 1 | High-half overflow in split mode |
| zero_o | output | 1 | Last result was zero |
| neg_o | output | 1 | Last result bit 39 |

## Verification
On every cycle, the assertions check the rules on holding and routing. With no write, nothing changes. A write leaves the other accumulator alone, and a disabled field stays unchanged. The high-half flag stays clear outside split mode, and the zero and sign flags agree with a fully written accumulator. The arithmetic itself can only be shown by the bench's scenarios against its reference model. This covers sign extension per size, the overflow thresholds at 16, 32 and 40 bits, the Boolean and load results, and the carry isolation between split halves.

// File: rtl/dsp_alu40.sv
module dsp_alu40 #(
  parameter int W = 40,
  parameter int H = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_i,
  input  logic         acc_sel_i,
  input  logic [2:0]   op_i,
  input  logic [1:0]   size_i,
  input  logic         split_i,
  input  logic         dst_sel_i,
  input  logic         wr_en_i,
  input  logic [2:0]   fld_we_i,
  output logic [W-1:0] acc_a_o,
  output logic [W-1:0] acc_b_o,
  output logic         ovf_lo_o,
  output logic         ovf_hi_o,
  output logic         zero_o,
  output logic         neg_o
);
  localparam int L = 2 * H;
  localparam int G = W - L;

  function automatic logic [W:0] sext(input logic [W-1:0] v, input int n);
    logic signed [W:0] t;
    t = $signed({v, 1'b0}) <<< (W - n);
    return t >>> (W - n + 1);
  endfunction

  function automatic logic [W:0] alu_f(input logic [2:0] op, input logic [W:0] a, input logic [W:0] b);
    case (op)
      3'd0:    return a + b;
      3'd1:    return a - b;
      3'd2:    return a & b;
      3'd3:    return a | b;
      3'd4:    return a ^ b;
      default: return b;
    endcase
  endfunction

  function automatic logic fits(input logic [W:0] v, input int n);
    logic signed [W:0] t;
    t = $signed(v) >>> (n - 1);
    return (t == '0) || (t == '1);
  endfunction

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw, input logic [2:0] m);
    logic [W-1:0] r;
    r = old;
    if (m[0]) r[H-1:0] = nw[H-1:0];
    if (m[1]) r[L-1:H] = nw[L-1:H];
    if (m[2]) r[W-1:L] = nw[W-1:L];
    return r;
  endfunction

  logic [W-1:0] acc_src;
  logic [W-1:0] opnd_lo, opnd_hi, acc_lo, acc_hi;
  logic [W:0]   x_w, y_w, s_w, s_lo, s_hi;
  logic [W-1:0] res;
  logic         ov_lo, ov_hi;
  int           nbits;

  assign acc_src = acc_sel_i ? acc_b_o : acc_a_o;
  assign opnd_lo = opnd_i;
  assign acc_lo  = acc_src;
  assign opnd_hi = opnd_i >> H;
  assign acc_hi  = acc_src >> H;

  always_comb begin
    case (size_i)
      2'd0:    nbits = H;
      2'd1:    nbits = L;
      default: nbits = W;
    endcase
  end

  assign x_w  = sext(opnd_i, nbits);
  assign y_w  = sext(acc_src, nbits);
  assign s_w  = alu_f(op_i, y_w, x_w);
  assign s_lo = alu_f(op_i, sext(acc_lo, H), sext(opnd_lo, H));
  assign s_hi = alu_f(op_i, sext(acc_hi, H), sext(opnd_hi, H));

  always_comb begin
    if (split_i) begin
      res   = {{G{s_hi[H-1]}}, s_hi[H-1:0], s_lo[H-1:0]};
      ov_lo = !fits(s_lo, H);
      ov_hi = !fits(s_hi, H);
    end else begin
      res   = s_w[W-1:0];
      ov_lo = !fits(s_w, nbits);
      ov_hi = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a_o  <= '0;
      acc_b_o  <= '0;
      ovf_lo_o <= 1'b0;
      ovf_hi_o <= 1'b0;
      zero_o   <= 1'b0;
      neg_o    <= 1'b0;
    end else if (wr_en_i) begin
      if (!dst_sel_i) acc_a_o <= merge(acc_a_o, res, fld_we_i);
      else            acc_b_o <= merge(acc_b_o, res, fld_we_i);
      ovf_lo_o <= ov_lo;
      ovf_hi_o <= ov_hi;
      zero_o   <= (res == '0);
      neg_o    <= res[W-1];
    end
  end
endmodule

module dsp_alu40_chk #(
  parameter int W = 40,
  parameter int H = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         split_i,
  input logic         dst_sel_i,
  input logic         wr_en_i,
  input logic [2:0]   fld_we_i,
  input logic [W-1:0] acc_a_o,
  input logic [W-1:0] acc_b_o,
  input logic         ovf_lo_o,
  input logic         ovf_hi_o,
  input logic         zero_o,
  input logic         neg_o
);
  localparam int L = 2 * H;

  p_hold_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(acc_a_o) && $stable(acc_b_o) && $stable(ovf_lo_o)
                 && $stable(ovf_hi_o) && $stable(zero_o) && $stable(neg_o));

  p_other_acc_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && dst_sel_i |=> $stable(acc_a_o));

  p_other_acc_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !dst_sel_i |=> $stable(acc_b_o));

  p_guard_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !dst_sel_i && !fld_we_i[2] |=> $stable(acc_a_o[W-1:L]));

  p_low_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && dst_sel_i && !fld_we_i[0] |=> $stable(acc_b_o[H-1:0]));

  p_no_hi_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !split_i |=> !ovf_hi_o);

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !dst_sel_i && fld_we_i == 3'b111 |=> zero_o == (acc_a_o == '0));

  p_neg_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && dst_sel_i && fld_we_i == 3'b111 |=> neg_o == acc_b_o[W-1]);
endmodule

bind dsp_alu40 dsp_alu40_chk #(.W(W), .H(H)) u_chk (.*);

// File: tb/dsp_alu40_bench.sv
module dsp_alu40_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] opnd_i = '0;
  logic        acc_sel_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic        split_i = 1'b0;
  logic        dst_sel_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  fld_we_i = 3'b111;
  logic [39:0] acc_a_o, acc_b_o;
  logic        ovf_lo_o, ovf_hi_o, zero_o, neg_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [39:0] ma = '0, mb = '0;
  logic        mol = 0, moh = 0, mz = 0, mn = 0;

  always #2 clk = ~clk;

  dsp_alu40 u_dsp_alu40 (.*);

  function automatic longint sx(input logic [39:0] v, input int n);
    longint t;
    t = longint'({24'b0, v});
    t = t <<< (64 - n);
    return t >>> (64 - n);
  endfunction

  function automatic longint opf(input logic [2:0] op, input longint a, input longint b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      default: return b;
    endcase
  endfunction

  function automatic bit outr(input longint r, input int n);
    longint lim;
    lim = longint'(1) <<< (n - 1);
    return (r >= lim) || (r < -lim);
  endfunction

  task automatic compare(input string tag);
    logic [40:0] got, exp;
    got = {acc_a_o, 1'b0} ^ 41'(0);
    n_cmp++;
    if (acc_a_o !== ma || acc_b_o !== mb || ovf_lo_o !== mol || ovf_hi_o !== moh
        || zero_o !== mz || neg_o !== mn) begin
      n_bad++;
      exp = {ma, 1'b0};
      $display("FAIL %s: A=%h B=%h ovl=%b ovh=%b z=%b n=%b expected A=%h B=%h ovl=%b ovh=%b z=%b n=%b",
               tag, acc_a_o, acc_b_o, ovf_lo_o, ovf_hi_o, zero_o, neg_o,
               ma, mb, mol, moh, mz, mn);
      if (got == exp) begin end
    end
  endtask

  task automatic step(input string tag, input logic [39:0] d, input logic as, input logic [2:0] op,
                      input logic [1:0] sz, input logic sp, input logic ds, input logic we,
                      input logic [2:0] fm);
    logic [39:0] src, res, nw;
    longint r, rl, rh;
    int n;
    bit ol, oh;
    opnd_i = d; acc_sel_i = as; op_i = op; size_i = sz;
    split_i = sp; dst_sel_i = ds; wr_en_i = we; fld_we_i = fm;
    src = as ? mb : ma;
    if (sp) begin
      rl = opf(op, sx(src, 16), sx(d, 16));
      rh = opf(op, sx(src >> 16, 16), sx(d >> 16, 16));
      ol = outr(rl, 16);
      oh = outr(rh, 16);
      res = {{8{rh[15]}}, rh[15:0], rl[15:0]};
    end else begin
      n = (sz == 0) ? 16 : (sz == 1) ? 32 : 40;
      r = opf(op, sx(src, n), sx(d, n));
      ol = outr(r, n);
      oh = 0;
      res = r[39:0];
    end
    @(posedge clk);
    if (we) begin
      nw = ds ? mb : ma;
      if (fm[0]) nw[15:0] = res[15:0];
      if (fm[1]) nw[31:16] = res[31:16];
      if (fm[2]) nw[39:32] = res[39:32];
      if (ds) mb = nw; else ma = nw;
      mol = ol; moh = oh; mz = (res == 0); mn = res[39];
    end
    #1;
    compare(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #5;
    compare("R1 reset");
    rst_n = 1'b1;
    #3;
    // R2: 40-bit add/sub and overflow
    step("R2 load max", 40'h7F_FFFF_FFFF, 0, 5, 2, 0, 0, 1, 3'b111);
    step("R2 add ovf40", 40'h00_0000_0001, 0, 0, 2, 0, 0, 1, 3'b111);
    step("R2 sub ovf40", 40'h00_0000_0001, 0, 1, 3, 0, 0, 1, 3'b111);
    step("R2 sub to zero", 40'h7F_FFFF_FFFF, 0, 1, 2, 0, 0, 1, 3'b111);
    // R3: 32- and 16-bit with guard retention
    step("R3 load 32max", 40'h00_7FFF_FFFF, 0, 5, 1, 0, 0, 1, 3'b111);
    step("R3 add ovf32", 40'hAB_0000_0001, 0, 0, 1, 0, 0, 1, 3'b111);
    step("R3 load 16max", 40'h00_0000_7FFF, 0, 5, 0, 0, 0, 1, 3'b111);
    step("R3 add ovf16", 40'hFF_FFFF_0001, 0, 0, 0, 0, 0, 1, 3'b111);
    step("R3 sub neg16", 40'h00_0000_7FFF, 0, 1, 0, 0, 0, 1, 3'b111);
    // R4: Boolean ops and load
    step("R4 load pat", 40'h12_F0F0_0FF0, 0, 5, 2, 0, 0, 1, 3'b111);
    step("R4 and", 40'hFF_FF00_FF00, 0, 2, 2, 0, 0, 1, 3'b111);
    step("R4 or", 40'h00_0000_000F, 0, 3, 2, 0, 0, 1, 3'b111);
    step("R4 xor 16", 40'h00_0000_8000, 0, 4, 0, 0, 0, 1, 3'b111);
    // R5: split mode
    step("R5 load split", 40'h00_7FFF_FFFF, 0, 5, 2, 0, 0, 1, 3'b111);
    step("R5 split add", 40'h00_0001_0001, 0, 0, 1, 1, 0, 1, 3'b111);
    step("R5 split sub", 40'h00_0001_8000, 0, 1, 0, 1, 0, 1, 3'b111);
    step("R5 split and", 40'hFF_F00F_00FF, 0, 2, 2, 1, 0, 1, 3'b111);
    // R6: source select, R7: destination and hold
    step("R6 load B", 40'h01_0000_0010, 0, 5, 2, 0, 1, 1, 3'b111);
    step("R6 add from B into A", 40'h00_0000_0005, 1, 0, 2, 0, 0, 1, 3'b111);
    step("R7 no write", 40'h55_5555_5555, 0, 0, 2, 0, 0, 0, 3'b111);
    step("R7 no write B", 40'h55_5555_5555, 1, 4, 2, 1, 1, 0, 3'b111);
    // R8: field masks
    step("R8 guard only", 40'hA5_1234_5678, 0, 5, 2, 0, 0, 1, 3'b100);
    step("R8 high only", 40'hA5_1234_5678, 0, 5, 2, 0, 1, 1, 3'b010);
    step("R8 low only", 40'hA5_1234_5678, 1, 5, 2, 0, 0, 1, 3'b001);
    step("R8 none", 40'hFF_FFFF_FFFF, 0, 5, 2, 0, 1, 1, 3'b000);
    // R9: zero and sign flags
    step("R9 zero", 40'h00_0000_0000, 0, 5, 2, 0, 0, 1, 3'b111);
    step("R9 neg", 40'h80_0000_0000, 0, 5, 2, 0, 1, 1, 3'b111);
    for (int i = 0; i < 4000; i++) begin
      logic [39:0] d;
      d = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      if (i % 7 == 0) d = {$urandom_range(1) ? 8'hFF : 8'h00, 16'h7FFF, 16'h8000 ^ 16'($urandom_range(3))};
      step("R2-mix random", d, 1'($urandom), 3'($urandom), 2'($urandom),
           ($urandom_range(3) == 0), 1'($urandom), ($urandom_range(7) != 0), 3'($urandom));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule